// File: doc/BRIEF.md
# Comparator Event Flag Register

This block is the digital side of an analog comparator. It takes the comparator's raw output bit, which can change at any time, and passes it through a two-flop synchronizer. From the synchronized value it detects low-to-high and high-to-low transitions. Each kind of transition sets its own sticky event flag. Software clears a flag by writing a one to its bit.

One interrupt line is asserted whenever a flag is set and the enable for that flag is also set. The block has a low-power stop input. While it is high, a control bit chooses how the flags are set. With the bit at zero, the flags follow the comparator level. With the bit at one, they keep capturing transitions. A two-bit hysteresis setting is stored in the register and driven straight out to the analog circuit.

Software reaches everything through one 16-bit register with a single write strobe and a read port that is always valid.

Top module: `cmp_evt_reg`

## Requirements
- R1: After reset the register reads 16'h0040. That is hysteresis field (bits 7:6) = 1, and every other bit is 0 while the comparator input is low. `hyst_sel` is 1 and `irq` is 0.
- R2: Bits 15:8 always read as zero. Writing ones to them has no effect on any field.
- R3: Bit 0 reads the comparator input two clock edges after the input changes. It is read-only.
- R4: With `stop_mode` low, a rise of the synchronized input sets the rising flag (bit 2). A fall sets the falling flag (bit 1). Each flag reads as set on the edge after the change appears in bit 0.
- R5: Writing a one to bit 2 or bit 1 clears that flag. Writing a zero leaves it unchanged.
- R6: If a flag's set event and a write-one-to-clear of that flag fall in the same cycle, the flag stays set.
- R7: `irq` equals (bit 2 AND bit 4) OR (bit 1 AND bit 3). Bit 4 is the rising enable and bit 3 is the falling enable.
- R8: With `stop_mode` high and bit 5 = 0, the flags are level sensitive. The rising flag is set in every cycle the synchronized input is high, so clearing it does not take effect. The falling flag behaves the same way while the input is low.
- R9: With `stop_mode` high and bit 5 = 1, the flags are set only by transitions, as in R4. A steady input sets nothing.
- R10: Bits 7:6 are read/write, accept 0 to 3, and drive `hyst_sel` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Unsynchronized comparator output |
| stop_mode | input | 1 | High while the chip is in stop mode |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| hyst_sel | output | 2 | Hysteresis setting to the analog side |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the cycle in which a flag's set event and a software clear coincide. The set event exists for only one clock, and it comes three edges after the input moves. The bench changes the input and counts two falling edges. It then holds the write strobe across exactly the third rising edge, so the clear and the set collide there. Level capture in stop mode is reached by holding the input steady and issuing a clear: the flag must not drop, which shows the set is being applied again every cycle.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int REG_W       = 16;
  localparam int HYST_W      = 2;
  localparam int STAT_B      = 0;
  localparam int FLAG_LO_B   = 1;  // bit 1 falling flag, bit 2 rising flag
  localparam int FALL_IE_B   = 3;
  localparam int RISE_IE_B   = 4;
  localparam int STOP_EDGE_B = 5;
  localparam int HYST_LO_B   = 6;
  localparam int USED_W      = HYST_LO_B + HYST_W;
  localparam logic [HYST_W-1:0] HYST_RST = HYST_W'(1);

  // sticky flag update: a set beats a clear
  function automatic logic flag_next(logic cur, logic set_evt, logic clr_req);
    return set_evt | (cur & ~clr_req);
  endfunction

  // returns {rise_set, fall_set}
  function automatic logic [1:0] set_select(logic stop, logic edge_mode,
                                            logic lvl, logic rise_e, logic fall_e);
    if (stop && !edge_mode) return {lvl, ~lvl};
    return {rise_e, fall_e};
  endfunction
endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag
  import cmp_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_evt, clr_req);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/cmp_evt_reg.sv
module cmp_evt_reg
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              stop_mode,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [HYST_W-1:0] hyst_sel,
  output logic              irq
);
  logic              status;
  logic              status_prev;
  logic              rise_evt, fall_evt;
  logic [1:0]        set_vec, clr_vec, flag_vec, ie_vec;
  logic [HYST_W-1:0] hyst_q;
  logic              stop_edge_q, rise_ie_q, fall_ie_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:USED_W];

  cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(status));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_prev <= 1'b0;
    else        status_prev <= status;

  assign rise_evt = status & ~status_prev;
  assign fall_evt = ~status & status_prev;

  // control fields
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hyst_q      <= HYST_RST;
      stop_edge_q <= 1'b0;
      rise_ie_q   <= 1'b0;
      fall_ie_q   <= 1'b0;
    end else if (wr_en) begin
      hyst_q      <= wr_data[HYST_LO_B +: HYST_W];
      stop_edge_q <= wr_data[STOP_EDGE_B];
      rise_ie_q   <= wr_data[RISE_IE_B];
      fall_ie_q   <= wr_data[FALL_IE_B];
    end

  assign set_vec = set_select(stop_mode, stop_edge_q, status, rise_evt, fall_evt);
  assign ie_vec  = {rise_ie_q, fall_ie_q};

  // index 0 = falling flag (bit 1), index 1 = rising flag (bit 2)
  generate
    for (genvar i = 0; i < 2; i++) begin : g_flag
      assign clr_vec[i] = wr_en & wr_data[FLAG_LO_B + i];
      cmp_evt_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .set_evt(set_vec[i]), .clr_req(clr_vec[i]), .flag_q(flag_vec[i]));
    end
  endgenerate

  assign irq      = |(flag_vec & ie_vec);
  assign hyst_sel = hyst_q;

  always_comb begin
    rd_data                         = '0;
    rd_data[HYST_LO_B +: HYST_W]    = hyst_q;
    rd_data[STOP_EDGE_B]            = stop_edge_q;
    rd_data[RISE_IE_B]              = rise_ie_q;
    rd_data[FALL_IE_B]              = fall_ie_q;
    rd_data[FLAG_LO_B +: 2]         = flag_vec;
    rd_data[STAT_B]                 = status;
  end

  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !stop_edge_q && status) |=> flag_vec[1]);
  assert_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && stop_edge_q && $rose(status)) |=> flag_vec[1]);
  assert_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && $fell(status)) |=> flag_vec[0]);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ie_q && !fall_ie_q) |-> !irq);
endmodule

// File: tb/cmp_evt_reg_tb.sv
module cmp_evt_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_raw = 1'b0;
  logic        stop_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [1:0]  hyst_sel;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_evt_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .stop_mode(stop_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hyst_sel(hyst_sel), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 16'h0;
  endtask

  // settle input and clear both flags, control = hysteresis 1 only
  task automatic clean(logic lvl);
    stop_mode = 1'b0; cmp_raw = lvl;
    tick(4);
    wr(16'h0046);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 16'h0040);
    chk("R1 hyst_sel", {14'h0, hyst_sel}, 16'h1);
    chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_status_rise;
    cmp_raw = 1'b1;
    tick(1); chk("R3 status after 1 edge", {15'h0, rd_data[0]}, 16'h0);
    tick(1); chk("R3 status after 2 edges", {15'h0, rd_data[0]}, 16'h1);
    chk("R4 rise flag not yet", {15'h0, rd_data[2]}, 16'h0);
    tick(1); chk("R4 rise flag set", {15'h0, rd_data[2]}, 16'h1);
    wr(16'h0041);  // bit 0 written, read-only
    chk("R3 status read-only", {15'h0, rd_data[0]}, 16'h1);
  endtask

  task automatic t_w1c;
    wr(16'h0040);
    chk("R5 write zero keeps flag", {15'h0, rd_data[2]}, 16'h1);
    wr(16'h0044);
    chk("R5 write one clears", rd_data, 16'h0041);
    cmp_raw = 1'b0; tick(3);
    chk("R4 fall flag set", rd_data[2:0], 3'b010);
    wr(16'h0042);
    chk("R5 fall flag cleared", rd_data, 16'h0040);
  endtask

  task automatic t_irq;
    clean(1'b0);
    wr(16'h0050);
    chk("R7 enable no flag", {15'h0, irq}, 16'h0);
    cmp_raw = 1'b1; tick(3);
    chk("R7 rise irq", {15'h0, irq}, 16'h1);
    wr(16'h0048);
    chk("R7 rise flag, only fall enabled", {15'h0, irq}, 16'h0);
    cmp_raw = 1'b0; tick(3);
    chk("R7 fall irq", {15'h0, irq}, 16'h1);
    wr(16'h004E);
    chk("R7 cleared irq", {15'h0, irq}, 16'h0);
    chk("R5 both cleared", rd_data, 16'h0048);
  endtask

  task automatic t_collide;
    clean(1'b0);
    cmp_raw = 1'b1;
    tick(2);
    wr(16'h0044);  // strobe spans the edge that sets the rising flag
    chk("R6 set wins", {15'h0, rd_data[2]}, 16'h1);
    wr(16'h0044);
    chk("R6 later clear works", {15'h0, rd_data[2]}, 16'h0);
  endtask

  task automatic t_stop_level;
    clean(1'b1);
    stop_mode = 1'b1;
    tick(1);
    chk("R8 level rise flag", rd_data[2:1], 2'b10);
    wr(16'h0044);
    chk("R8 clear overridden", {15'h0, rd_data[2]}, 16'h1);
    cmp_raw = 1'b0; tick(3);
    chk("R8 level fall flag", {15'h0, rd_data[1]}, 16'h1);
    wr(16'h0042);
    chk("R8 fall clear overridden", {15'h0, rd_data[1]}, 16'h1);
    wr(16'h0044);
    chk("R8 rise clears when low", {15'h0, rd_data[2]}, 16'h0);
    stop_mode = 1'b0;
  endtask

  task automatic t_stop_edge;
    clean(1'b0);
    wr(16'h0060);
    stop_mode = 1'b1;
    tick(5);
    chk("R9 steady sets nothing", rd_data, 16'h0060);
    cmp_raw = 1'b1; tick(3);
    chk("R9 edge rise", rd_data, 16'h0065);
    cmp_raw = 1'b0; tick(3);
    chk("R9 edge fall", rd_data[2:1], 2'b11);
    stop_mode = 1'b0;
  endtask

  task automatic t_fields;
    clean(1'b0);
    wr(16'hFFC0);
    chk("R2 reserved read zero", {8'h0, rd_data[15:8]}, 16'h0);
    chk("R2 reserved write ignored", rd_data, 16'h00C0);
    chk("R10 hyst 3", {14'h0, hyst_sel}, 16'h3);
    wr(16'h0000);
    chk("R10 hyst 0", {14'h0, hyst_sel}, 16'h0);
    wr(16'h0080);
    chk("R10 hyst 2", {14'h0, hyst_sel}, 16'h2);
    chk("R10 readback", rd_data, 16'h0080);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_status_rise();
    t_w1c();
    t_irq();
    t_collide();
    t_stop_level();
    t_stop_edge();
    t_fields();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule